// File: doc/BRIEF.md
# Pseudo-Noise Shift-Register Sequence Generator

This block produces a maximal-length pseudo-noise bit stream from a linear feedback shift register. On every enabled clock the register moves its contents one stage toward stage 0. The modulo-2 sum of a fixed set of tapped stages enters the highest stage. The stream is read serially from stage 0, and the whole register is also visible on a parallel output.

The stage count is a build-time parameter with two supported settings. Fifteen stages use the in-phase spreading polynomial x^15 + x^13 + x^9 + x^8 + x^7 + x^5 + 1. Three stages give a short reference sequence that is easy to check. Software or a sequencer can restart the stream from any seed. A seed of all zeros would lock the register, so the block replaces it with the default seed.

Top module: `pn_gen`

## Requirements
- R1: While the synchronous active-low reset is low at a clock edge, the register takes the default seed, which has only stage 0 set (value 1), so the serial output reads 1.
- R2: On an enabled clock without a load, every stage i below the top takes the old value of stage i+1, so the register shifts toward stage 0.
- R3: On such a clock, the top stage takes the XOR of the tapped stages. With 15 stages the taps are 0, 5, 7, 8, 9 and 13. With 3 stages the taps are 0 and 1.
- R4: With 3 stages and starting from 001 (written as stage 2, stage 1, stage 0), successive enabled clocks give 100, 010, 101, 110, 111, 011 and then 001 again.
- R5: The serial output equals stage 0. With 3 stages, starting from 001 and read before each shift, it gives 1,0,0,1,0,1,1 and then repeats.
- R6: With enable low and no load, the register and the serial output keep their values.
- R7: A load strobe with a non-zero seed puts that seed in the register at the next edge. This also happens when enable is high, because the load wins over the shift.
- R8: A load strobe with an all-zero seed loads the default seed (value 1) instead.
- R9: The register never holds all zeros after reset. With 15 stages it first returns to its starting state after exactly 32767 enabled clocks.
- R10: Over one period the serial output contains 2^(N-1) ones: 4 of 7 with 3 stages, and 16384 of 32767 with 15 stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| shiftEn | input | 1 | Advance the sequence by one step |
| seedLoad | input | 1 | Load the seed value at the next edge |
| seedVal | input | STAGES | Seed to load; stage 0 is bit 0 |
| serialOut | output | 1 | Current stage 0 value |
| stateOut | output | STAGES | Full register contents |

## Verification
The two functions that can fall in the same cycle are the seed load and the shift: both the load strobe and the enable are high at one edge. The bench provokes this for every 3-stage seed, the zero seed included, and for a 15-stage seed. It checks that the register holds exactly the loaded value, or the default seed for zero, and not the shifted value. The bench works out every expected state itself, from the polynomial exponents or from the listed reference sequence.

// File: rtl/pn_pkg.sv
package pn_pkg;

  typedef struct packed {
    logic load;
    logic shift;
  } pnStrobe_t;

  // Feedback tap mask for a given stage count (bit i set = stage i tapped).
  function automatic int unsigned tapMaskFor(input int unsigned stages);
    int unsigned mask;
    case (stages)
      3:       mask = 32'h0000_0003;
      15:      mask = 32'h0000_23A1;
      default: mask = 32'h0000_0003;
    endcase
    return mask;
  endfunction

endpackage

// File: rtl/pn_ctrl.sv
module pn_ctrl
  import pn_pkg::*;
#(
  parameter int unsigned STAGES = 15
) (
  input  logic              shiftEn,
  input  logic              seedLoad,
  input  logic [STAGES-1:0] seedVal,
  output pnStrobe_t         strobe,
  output logic [STAGES-1:0] loadVal
);

  localparam logic [STAGES-1:0] DEFAULT_SEED = {{(STAGES-1){1'b0}}, 1'b1};

  logic seedIsZero;

  always_comb begin
    seedIsZero   = (seedVal == '0);
    loadVal      = seedIsZero ? DEFAULT_SEED : seedVal;
    strobe.load  = seedLoad;
    strobe.shift = shiftEn & ~seedLoad;
  end

endmodule

// File: rtl/pn_shift.sv
module pn_shift
  import pn_pkg::*;
#(
  parameter int unsigned       STAGES = 15,
  parameter logic [STAGES-1:0] TAPS   = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  pnStrobe_t         strobe,
  input  logic [STAGES-1:0] loadVal,
  output logic [STAGES-1:0] state
);

  localparam logic [STAGES-1:0] DEFAULT_SEED = {{(STAGES-1){1'b0}}, 1'b1};

  logic [STAGES-1:0] tapped;
  logic              feedback;

  for (genvar i = 0; i < STAGES; i++) begin : g_tap
    if (TAPS[i]) begin : g_on
      assign tapped[i] = state[i];
    end else begin : g_off
      assign tapped[i] = 1'b0;
    end
  end

  assign feedback = ^tapped;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= DEFAULT_SEED;
    end else if (strobe.load) begin
      state <= loadVal;
    end else if (strobe.shift) begin
      state <= {feedback, state[STAGES-1:1]};
    end
  end

endmodule

// File: rtl/pn_gen.sv
module pn_gen
  import pn_pkg::*;
#(
  parameter int unsigned STAGES = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              shiftEn,
  input  logic              seedLoad,
  input  logic [STAGES-1:0] seedVal,
  output logic              serialOut,
  output logic [STAGES-1:0] stateOut
);

  localparam int unsigned       TAP_INT = tapMaskFor(STAGES);
  localparam logic [STAGES-1:0] TAPS    = TAP_INT[STAGES-1:0];

  pnStrobe_t         strobe;
  logic [STAGES-1:0] loadVal;
  logic [STAGES-1:0] state;

  pn_ctrl #(.STAGES(STAGES)) u_ctrl (
    .shiftEn (shiftEn),
    .seedLoad(seedLoad),
    .seedVal (seedVal),
    .strobe  (strobe),
    .loadVal (loadVal)
  );

  pn_shift #(.STAGES(STAGES), .TAPS(TAPS)) u_shift (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .loadVal(loadVal),
    .state  (state)
  );

  assign stateOut  = state;
  assign serialOut = state[0];

endmodule

// File: rtl/pn_gen_chk.sv
module pn_gen_chk #(
  parameter int unsigned STAGES = 15
) (
  input logic              clk,
  input logic              rstN,
  input logic              shiftEn,
  input logic              seedLoad,
  input logic [STAGES-1:0] seedVal,
  input logic [STAGES-1:0] stateOut
);

  localparam int unsigned       MASK_INT = (STAGES == 15) ? 32'h23A1 : 32'h3;
  localparam logic [STAGES-1:0] MASK     = MASK_INT[STAGES-1:0];
  localparam logic [STAGES-1:0] ONE      = {{(STAGES-1){1'b0}}, 1'b1};

  AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    stateOut != '0); // R9

  AST_SHIFT_RIGHT: assert property (@(posedge clk) disable iff (!rstN)
    (shiftEn && !seedLoad) |=> stateOut[STAGES-2:0] == $past(stateOut[STAGES-1:1])); // R2

  AST_FEEDBACK_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (shiftEn && !seedLoad) |=> stateOut[STAGES-1] == ^($past(stateOut) & MASK)); // R3

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!shiftEn && !seedLoad) |=> $stable(stateOut)); // R6

  AST_LOAD_SEED: assert property (@(posedge clk) disable iff (!rstN)
    (seedLoad && seedVal != '0) |=> stateOut == $past(seedVal)); // R7

  AST_ZERO_SEED: assert property (@(posedge clk) disable iff (!rstN)
    (seedLoad && seedVal == '0) |=> stateOut == ONE); // R8

endmodule

bind pn_gen pn_gen_chk #(.STAGES(STAGES)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .shiftEn (shiftEn),
  .seedLoad(seedLoad),
  .seedVal (seedVal),
  .stateOut(stateOut)
);

// File: tb/pn_gen_tb.sv
`timescale 1ns/1ps
module pn_gen_tb;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN = 1'b0;

  logic        bEn = 1'b0, bLoad = 1'b0;
  logic [14:0] bSeed = '0;
  logic        bSer;
  logic [14:0] bState;

  logic        sEn = 1'b0, sLoad = 1'b0;
  logic [2:0]  sSeed = '0;
  logic        sSer;
  logic [2:0]  sState;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  pn_gen #(.STAGES(15)) u_dut (
    .clk(clk), .rstN(rstN), .shiftEn(bEn), .seedLoad(bLoad), .seedVal(bSeed),
    .serialOut(bSer), .stateOut(bState)
  );

  pn_gen #(.STAGES(3)) u_small (
    .clk(clk), .rstN(rstN), .shiftEn(sEn), .seedLoad(sLoad), .seedVal(sSeed),
    .serialOut(sSer), .stateOut(sState)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Feedback mask built from the polynomial exponents below the degree.
  function automatic logic [14:0] bigMask();
    int exps[6] = '{13, 9, 8, 7, 5, 0};
    logic [14:0] m = '0;
    foreach (exps[k]) m[exps[k]] = 1'b1;
    return m;
  endfunction

  function automatic logic [14:0] bigNext(input logic [14:0] s);
    return {^(s & bigMask()), s[14:1]};
  endfunction

  function automatic logic [2:0] smallNext(input logic [2:0] s);
    return {s[0] ^ s[1], s[2:1]};
  endfunction

  initial begin
    #1_500_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [2:0] expSeq[7] = '{3'b100, 3'b010, 3'b101, 3'b110, 3'b111, 3'b011, 3'b001};
    logic [6:0] expBits = 7'b1001011;
    logic [14:0] model;
    int firstReturn;
    int ones;
    int mism;
    int zeroSeen;

    @(negedge clk);
    repeat (3) step();
    // R1: reset state
    chk(bState == 15'd1, "R1", "big reset state", bState, 1);
    chk(bSer == 1'b1, "R1", "big serial after reset", bSer, 1);
    chk(sState == 3'd1, "R1", "small reset state", sState, 1);
    rstN = 1'b1;
    step();
    chk(bState == 15'd1 && sState == 3'd1, "R6", "idle after reset", bState, 1);

    // R4, R5, R10: 3-stage reference sequence and output bits
    sEn = 1'b1;
    ones = 0;
    for (int i = 0; i < 7; i++) begin
      chk(sSer == expBits[6-i], "R5", "small serial bit", sSer, expBits[6-i]);
      ones += sSer;
      step();
      chk(sState == expSeq[i], "R4", "small state sequence", sState, expSeq[i]);
    end
    chk(ones == 4, "R10", "small ones per period", ones, 4);
    sEn = 1'b0;

    // R6: hold with enable low
    for (int i = 0; i < 3; i++) begin
      step();
      chk(sState == 3'b001 && sSer == 1'b1, "R6", "small hold", sState, 1);
    end

    // R2, R3: exhaustive single step from each non-zero state
    for (int s = 1; s < 8; s++) begin
      sLoad = 1'b1; sSeed = 3'(s);
      step();
      sLoad = 1'b0; sEn = 1'b1;
      step();
      sEn = 1'b0;
      chk(sState == smallNext(3'(s)), "R3", "small step from seed", sState, smallNext(3'(s)));
    end

    // R7, R8: load alone and load together with enable, for every seed
    for (int s = 0; s < 8; s++) begin
      for (int e = 0; e < 2; e++) begin
        sLoad = 1'b1; sSeed = 3'(s); sEn = e[0];
        step();
        sLoad = 1'b0; sEn = 1'b0;
        if (s == 0)
          chk(sState == 3'd1, "R8", "small zero seed load", sState, 1);
        else
          chk(sState == 3'(s), "R7", "small load priority", sState, s);
      end
    end

    // R9, R10, R2, R3: full 15-stage period from seed 1
    model = bState;
    firstReturn = 0; ones = 0; mism = 0; zeroSeen = 0;
    bEn = 1'b1;
    for (int i = 1; i <= 32767; i++) begin
      ones += bSer;
      step();
      model = bigNext(model);
      if (bState != model) mism++;
      if (bState == '0) zeroSeen++;
      if (bState == 15'd1 && firstReturn == 0) firstReturn = i;
    end
    bEn = 1'b0;
    chk(mism == 0, "R3", "big feedback and shift mismatches", mism, 0);
    chk(zeroSeen == 0, "R9", "big all-zero states seen", zeroSeen, 0);
    chk(firstReturn == 32767, "R9", "big period", firstReturn, 32767);
    chk(ones == 16384, "R10", "big ones per period", ones, 16384);

    // R6: 15-stage hold
    step(); step();
    chk(bState == 15'd1, "R6", "big hold", bState, 1);

    // R7: load together with enable on 15 stages
    bLoad = 1'b1; bSeed = 15'h5A5A; bEn = 1'b1;
    step();
    bLoad = 1'b0;
    chk(bState == 15'h5A5A, "R7", "big load with enable", bState, 15'h5A5A);
    step();
    chk(bState == bigNext(15'h5A5A), "R2", "big step after load", bState, bigNext(15'h5A5A));
    chk(bSer == bState[0], "R5", "big serial equals stage 0", bSer, bState[0]);
    bEn = 1'b0;

    // R8: zero seed on 15 stages, with enable high
    bLoad = 1'b1; bSeed = '0; bEn = 1'b1;
    step();
    bLoad = 1'b0; bEn = 1'b0;
    chk(bState == 15'd1, "R8", "big zero seed load", bState, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule